// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block is the digital side of a converter that runs a fixed cycle: it converts, then sleeps while holding the result, then shifts the result out over a three-wire serial link. The link has an active-low select, a serial clock driven by the host, and a data line with an output enable for a pad that goes high-impedance when the block is not selected. Conversion is modelled by a counter that runs for a set number of system clocks and then captures a 31-bit result from an input port. The controller puts a status bit in front of that result to make a 32-bit word.

While selected, the data line reports progress before any clock edge. It is high during a conversion and low once the result is ready. The host then reads 32 bits: it captures on rising serial clock edges, and the block launches each next bit on falling edges. The read ends after the 32nd falling edge or when select rises early. Either way a fresh conversion starts at once.

Select and serial clock are brought into the system clock domain through two-flop synchronisers. Edges are detected after synchronisation.

Top module: `adc_serial_ctrl`

## Requirements
- R1: The controller steps through convert, then sleep, then output, then back to convert, and never in any other order.
- R2: After a conversion ends, the controller stays in sleep for as long as select is high, and the held word does not change during that time.
- R3: While the synchronised select is high, sdo_oe is 0 and serial clock edges do not change the held word.
- R4: While selected during convert, sdo_data is 1. While selected during sleep, sdo_data is 0.
- R5: The output word is {1'b0, result_in[30:0]}, sent MSB first. Bit 31 is on sdo_data before the first rising serial clock edge, and bit 31-k follows the k-th falling edge, for k from 1 to 31.
- R6: After the 32nd falling edge, sdo_data goes to 1 and a new conversion is running.
- R7: If select rises before 32 falling edges, output ends and a new conversion starts. The next read begins again at bit 31 with the new result.
- R8: During reset sdo_oe is 0. A conversion starts when reset is released, and with select held low sdo_data falls to 0 exactly CONV_CYCLES system clocks after release.
- R9: A change on cs_n reaches the output enable after two system clock edges. The serial clock period must be at least four system clock periods.
- R10: Taking select low while a conversion runs does not restart that conversion. After a select rise ends a read, sdo_data falls exactly CONV_CYCLES+3 clocks later.
- R11: result_in is sampled only in the last cycle of a conversion. A later change does not alter the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| result_in | input | WORD_W-1 | Result supplied to the conversion engine |
| sdo_data | output | 1 | Serial data value |
| sdo_oe | output | 1 | Output enable for the data pad; 0 means high-impedance |

## Verification
The hardest situation to reach is a read that is cut short, followed by select going low again while the next conversion is still running. In that case end-of-conversion must come from the restarted conversion, with unchanged timing. The bench reads eight bits and raises select. It changes result_in and lowers select a few clocks later. It then counts system clocks until the data line drops and checks that the following read starts cleanly at bit 31 with the new result.

// File: rtl/adc_pkg.sv
package adc_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } adc_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= INIT;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= INIT;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_conv_engine.sv
module adc_conv_engine #(
  parameter int CONV_CYCLES = 40,
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  // A conversion is running after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt  <= cnt + 1'b1;
    end
  end

  assign done = busy && (cnt == CNT_W'(CONV_CYCLES - 1));
endmodule

// File: rtl/adc_shift_out.sv
module adc_shift_out #(
  parameter int WORD_W = 32,
  localparam int BC_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_en,
  output logic [WORD_W-1:0] word,
  output logic [BC_W-1:0]   bit_cnt,
  output logic              last_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      word    <= load_word;
      bit_cnt <= '0;
    end else if (shift_en) begin
      word    <= {word[WORD_W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign last_bit = (bit_cnt == BC_W'(WORD_W - 1));
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CONV_CYCLES = 40,
  localparam int BC_W = $clog2(WORD_W),
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [WORD_W-2:0] result_in,
  output logic              sdo_data,
  output logic              sdo_oe
);
  // Status bit (low = conversion finished) in front of the result.
  function automatic logic [WORD_W-1:0] frame_word(input logic [WORD_W-2:0] r);
    return {1'b0, r};
  endfunction

  logic [1:0]        sync_q;
  logic              cs_s, sclk_s, sclk_d;
  logic              cs_act, sclk_fall;
  adc_state_e        state, state_nxt;
  logic              conv_start, conv_busy, conv_done;
  logic [CNT_W-1:0]  conv_cnt;
  logic              load, shift_en, last_bit;
  logic [WORD_W-1:0] shreg;
  logic [BC_W-1:0]   bit_cnt;

  adc_sync #(.W(2), .STAGES(2), .INIT(2'b10)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk}), .q(sync_q)
  );
  assign cs_s   = sync_q[1];
  assign sclk_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign cs_act    = !cs_s;
  assign sclk_fall = sclk_d && !sclk_s;

  adc_conv_engine #(.CONV_CYCLES(CONV_CYCLES)) i_engine (
    .clk(clk), .rst_n(rst_n), .start(conv_start),
    .busy(conv_busy), .done(conv_done), .cnt(conv_cnt)
  );

  adc_shift_out #(.WORD_W(WORD_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_word(frame_word(result_in)),
    .shift_en(shift_en), .word(shreg), .bit_cnt(bit_cnt), .last_bit(last_bit)
  );

  always_comb begin
    state_nxt  = state;
    conv_start = 1'b0;
    load       = 1'b0;
    shift_en   = 1'b0;
    unique case (state)
      ST_CONV: if (conv_done) begin
        state_nxt = ST_SLEEP;
        load      = 1'b1;
      end
      ST_SLEEP: if (cs_act) state_nxt = ST_OUT;
      ST_OUT: begin
        if (!cs_act) begin
          state_nxt  = ST_CONV;
          conv_start = 1'b1;
        end else if (sclk_fall) begin
          shift_en = 1'b1;
          if (last_bit) begin
            state_nxt  = ST_CONV;
            conv_start = 1'b1;
          end
        end
      end
      default: state_nxt = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CONV;
    else        state <= state_nxt;
  end

  assign sdo_data = (state == ST_CONV) ? 1'b1 : shreg[WORD_W-1];
  assign sdo_oe   = cs_act;
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
module adc_serial_ctrl_chk
  import adc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BC_W = 5,
  parameter int CNT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input adc_state_e        state,
  input logic              cs_act,
  input logic              sclk_fall,
  input logic [BC_W-1:0]   bit_cnt,
  input logic [WORD_W-1:0] shreg,
  input logic              conv_busy,
  input logic              conv_done,
  input logic              conv_start,
  input logic [CNT_W-1:0]  conv_cnt
);
  p_conv_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) |=> (state != ST_OUT));
  p_sleep_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> (state != ST_CONV));
  p_sleep_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && !cs_act) |=> (state == ST_SLEEP && $stable(shreg)));
  p_deselect_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && state != ST_CONV) |=> $stable(shreg));
  p_last_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && cs_act && sclk_fall && bit_cnt == BC_W'(WORD_W - 1))
      |=> (state == ST_CONV && conv_busy));
  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUT && !cs_act) |=> (state == ST_CONV && conv_busy));
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done && !conv_start) |=> (conv_cnt == CNT_W'($past(conv_cnt) + 1'b1)));
  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && !conv_done) |=> (state == ST_CONV));
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.WORD_W(WORD_W), .BC_W(BC_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .cs_act(cs_act), .sclk_fall(sclk_fall),
  .bit_cnt(bit_cnt), .shreg(shreg), .conv_busy(conv_busy), .conv_done(conv_done),
  .conv_start(conv_start), .conv_cnt(conv_cnt)
);

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_LEN   = 40;
  localparam int HALF       = 6;
  localparam int NVEC       = 4;

  typedef struct packed {
    logic [30:0] stim;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t TABLE [NVEC] = '{
    '{31'h2AAA_AAAA, 32'h2AAA_AAAA},
    '{31'h7FFF_FFFF, 32'h7FFF_FFFF},
    '{31'h0000_0001, 32'h0000_0001},
    '{31'h4C3B_2A19, 32'h4C3B_2A19}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b0;
  logic        sclk = 1'b0;
  logic [30:0] result_in = 31'h1357_9BDF;
  logic        sdo_data, sdo_oe;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_ctrl #(.WORD_W(32), .CONV_CYCLES(CONV_LEN)) i_adc_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .result_in(result_in), .sdo_data(sdo_data), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Host read: capture before each rising edge, the block launches on falling edges.
  task automatic read_bits(input int n, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[31-i] = sdo_data;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] got;
    int n;
    // R8: reset with select held low
    repeat (3) @(negedge clk);
    chk(sdo_oe == 1'b0, "R8 oe in reset", 32'(sdo_oe), 32'd0);
    rst_n = 1'b1;
    n = 0;
    while (n < 4 * CONV_LEN) begin
      @(negedge clk);
      n++;
      if (sdo_data == 1'b0) break;
    end
    chk(n == CONV_LEN, "R8 first conversion length", 32'(n), 32'(CONV_LEN));
    repeat (2) @(negedge clk);
    read_bits(32, got);
    chk(got == {1'b0, 31'h1357_9BDF}, "R5 first word", got, {1'b0, 31'h1357_9BDF});
    chk(sdo_data == 1'b1 && sdo_oe, "R6 high after 32nd fall", 32'(sdo_data), 32'd1);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo_oe == 1'b0, "R3 deselected", 32'(sdo_oe), 32'd0);

    // Table walk: each pass starts with a conversion running
    for (int v = 0; v < NVEC; v++) begin
      result_in = TABLE[v].stim;
      for (int k = 0; k < 5; k++) begin  // R3: clock pulses while deselected
        sclk = 1'b1; repeat (HALF) @(negedge clk);
        sclk = 1'b0; repeat (HALF) @(negedge clk);
      end
      repeat (CONV_LEN) @(negedge clk);
      result_in = ~TABLE[v].stim;  // R11: must not reach the held word
      repeat (20) @(negedge clk);  // R2: long sleep
      cs_n = 1'b0;
      @(negedge clk);
      chk(sdo_oe == 1'b0, "R9 one edge after select", 32'(sdo_oe), 32'd0);
      @(negedge clk);
      chk(sdo_oe == 1'b1, "R9 two edges after select", 32'(sdo_oe), 32'd1);
      @(negedge clk);
      chk(sdo_data == 1'b0, "R4 ready flag low", 32'(sdo_data), 32'd0);
      read_bits(32, got);
      chk(got == TABLE[v].exp, "R5 R2 R11 word", got, TABLE[v].exp);
      chk(sdo_data == 1'b1, "R6 new conversion flag", 32'(sdo_data), 32'd1);
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(sdo_oe == 1'b0, "R3 high impedance", 32'(sdo_oe), 32'd0);
    end

    // Early end of a read, then select low during the new conversion
    result_in = 31'h0ABC_DEF1;
    repeat (CONV_LEN + 10) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    read_bits(8, got);
    chk(got[31:24] == 8'h0A, "R5 partial read", {24'd0, got[31:24]}, 32'h0A);
    result_in = 31'h6543_210F;
    cs_n = 1'b1;
    n = 0;
    repeat (4) begin @(negedge clk); n++; end
    chk(sdo_oe == 1'b0, "R7 deselect ends output", 32'(sdo_oe), 32'd0);
    cs_n = 1'b0;
    repeat (3) begin @(negedge clk); n++; end
    chk(sdo_data == 1'b1 && sdo_oe, "R4 R10 converting flag", 32'(sdo_data), 32'd1);
    while (n < 4 * CONV_LEN) begin
      @(negedge clk);
      n++;
      if (sdo_data == 1'b0) break;
    end
    chk(n == CONV_LEN + 3, "R10 conversion not restarted", 32'(n), 32'(CONV_LEN + 3));
    repeat (2) @(negedge clk);
    read_bits(32, got);
    chk(got == {1'b0, 31'h6543_210F}, "R7 R1 fresh word from bit 31", got, {1'b0, 31'h6543_210F});
    cs_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule